// File: doc/BRIEF.md
# Prioritized Fixed-Vector Interrupt Controller

This block sits beside a small 8-bit processor core. It collects several interrupt sources, picks one winner, and presents a single call request to the core. The core takes the request and receives one of two things with it. The first is a 16-bit call address. The second, for the general input, is a flag telling it to fetch the call opcode from the interrupting device. The core answers with a one-cycle acknowledge. After that the controller is free to raise the next request.

There are six kinds of source. A non-maskable line calls slot 4 plus half a slot. Three dedicated "half-step" lines call the midpoint of slots 5, 6 and 7. Each half-step address leaves four bytes between it and the restart slot below, which is room for one 3-byte jump. A general line gets its opcode from the device. Software restart requests carry a number n and call slot n. Software loads the half-step mask and a global enable. It reads back the mask, the enable and the request state through a status port.

The controller is a two-state machine. In `ST_IDLE` it watches the sampled sources. Transition `IDLE_TO_GRANT` fires on the first edge where any source is eligible, and the winner is stored. In `ST_GRANT` it holds `irq_out` and the stored call address. Transition `GRANT_TO_IDLE` fires on the edge where `ack` is high.

Top module: `fixvec_irq_ctrl`

## Requirements
- R1: A software request (`sw_valid`=1, `sw_num`=n, n in 0..7) is answered with `vec_out` = n*8 (00H..38H) and `ext_opcode`=0. Software requests ignore the mask and the global enable.
- R2: The non-maskable line is answered with `vec_out`=0024H, whatever the mask and the enable hold. It is armed by a rising edge and must still be high on the grant edge. A pulse that falls one cycle after rising is never granted. A line held high after its acknowledge is not granted again.
- R3: Half-step lines `hs_req[0]`, `hs_req[1]` and `hs_req[2]` are answered with 002CH, 0034H and 003CH respectively.
- R4: Priority, from highest to lowest: non-maskable, then `hs_req[2]`, `hs_req[1]`, `hs_req[0]`, then the general line, then software requests.
- R5: A granted general request raises `ext_opcode` with `vec_out`=0000H.
- R6: A write with `cfg_wr`=1 and `cfg_mask_en`=1 loads `cfg_mask`. A mask bit k of 1 blocks `hs_req[k]`. Reset leaves the mask at 111 and the enable at 0.
- R7: `hs_req[0]` and `hs_req[1]` are level requests, so a level dropped before it is eligible is never serviced. `hs_req[2]` sets a pending bit on its rising edge. That bit is remembered while the line is masked or low again. It clears on the acknowledge of its grant, or on a write with `cfg_wr`=1 and `cfg_clr75`=1. A line still held high after service is not granted again.
- R8: Half-step and general requests need the global enable at 1. `ie_set` sets it and `ie_clr` clears it. Granting a half-step or general request clears it in the same edge, and that wins over `ie_set`.
- R9: `status_out` bits [2:0] = mask, bit [3] = global enable, bits [4] and [5] = sampled levels of `hs_req[0]` and `hs_req[1]`, bit [6] = the `hs_req[2]` pending bit.
- R10: A request applied before edge k raises `irq_out` after edge k+1. `irq_out`, `vec_out` and `ext_opcode` stay stable until `ack`. `irq_out` falls after the edge that samples `ack`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request line |
| hs_req | input | 3 | Half-step request lines, bit 2 highest |
| gen_req | input | 1 | General request needing a device opcode |
| sw_valid | input | 1 | Software restart request |
| sw_num | input | 3 | Software restart number |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mask_en | input | 1 | Write qualifies a mask load |
| cfg_mask | input | 3 | New half-step mask, 1 = blocked |
| cfg_clr75 | input | 1 | Write clears the `hs_req[2]` pending bit |
| ie_set | input | 1 | Set global enable |
| ie_clr | input | 1 | Clear global enable |
| ack | input | 1 | Core acknowledge of the current request |
| irq_out | output | 1 | Request to the core |
| vec_out | output | 16 | Call address of the granted source |
| ext_opcode | output | 1 | Opcode must come from the device |
| status_out | output | 7 | Mask, enable and request state |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-byte slots, the non-maskable slot at 4 and the half-step slots starting at 5. With these values every one of the twelve fixed call addresses can be checked against a literal value. The three-bit software number reaches all eight restart slots. Random mixes of all six sources under random masks and enables exercise each priority pair. Directed runs cover the edge-armed cases, the level cases and the handshake timing.

// File: rtl/fixvec_irq_pkg.sv
package fixvec_irq_pkg;

    localparam int HS_N  = 3;
    localparam int IDX_W = 3;

    typedef enum logic [2:0] {
        K_NONE,
        K_NMI,
        K_HS,
        K_GEN,
        K_SW
    } src_kind_e;

    typedef struct packed {
        src_kind_e            kind;
        logic [IDX_W-1:0]     idx;
    } grant_t;

    typedef enum logic {
        ST_IDLE,
        ST_GRANT
    } ctl_state_e;

endpackage

// File: rtl/fixvec_irq_capture.sv
module fixvec_irq_capture
    import fixvec_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_in,
    input  logic [HS_N-1:0]  hs_req,
    input  logic             gen_req,
    input  logic             sw_valid,
    input  logic [IDX_W-1:0] sw_num,
    input  logic             nmi_done,
    input  logic             top_done,
    input  logic             top_flush,
    output logic             nmi_pend,
    output logic [HS_N-1:0]  hs_act,
    output logic             gen_q,
    output logic             sw_q,
    output logic [IDX_W-1:0] sw_idx_q
);

    logic            nmi_prev;
    logic [HS_N-1:0] hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
            hs_q     <= '0;
            gen_q    <= 1'b0;
            sw_q     <= 1'b0;
            sw_idx_q <= '0;
        end else begin
            nmi_prev <= nmi_in;
            hs_q     <= hs_req;
            gen_q    <= gen_req;
            sw_q     <= sw_valid;
            sw_idx_q <= sw_num;
            if (!nmi_in)
                nmi_pend <= 1'b0;
            else if (!nmi_prev)
                nmi_pend <= 1'b1;
            else if (nmi_done)
                nmi_pend <= 1'b0;
        end
    end

    // top half-step line is edge-armed, the others follow their sampled level
    generate
        for (genvar k = 0; k < HS_N; k++) begin : g_hs
            if (k == HS_N - 1) begin : g_edge
                logic pend;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        pend <= 1'b0;
                    else if (top_flush)
                        pend <= 1'b0;
                    else if (hs_req[k] && !hs_q[k])
                        pend <= 1'b1;
                    else if (top_done)
                        pend <= 1'b0;
                end
                assign hs_act[k] = pend;
            end else begin : g_level
                assign hs_act[k] = hs_q[k];
            end
        end
    endgenerate

endmodule

// File: rtl/fixvec_irq_prio.sv
module fixvec_irq_prio
    import fixvec_irq_pkg::*;
(
    input  logic             nmi_ok,
    input  logic [HS_N-1:0]  hs_ok,
    input  logic             gen_ok,
    input  logic             sw_ok,
    input  logic [IDX_W-1:0] sw_idx,
    output grant_t           sel
);

    // later assignments override earlier ones: lowest rank written first
    always_comb begin
        sel.kind = K_NONE;
        sel.idx  = '0;
        if (sw_ok) begin
            sel.kind = K_SW;
            sel.idx  = sw_idx;
        end
        if (gen_ok) begin
            sel.kind = K_GEN;
            sel.idx  = '0;
        end
        for (int k = 0; k < HS_N; k++) begin
            if (hs_ok[k]) begin
                sel.kind = K_HS;
                sel.idx  = IDX_W'(k);
            end
        end
        if (nmi_ok) begin
            sel.kind = K_NMI;
            sel.idx  = '0;
        end
    end

endmodule

// File: rtl/fixvec_irq_ctrl.sv
module fixvec_irq_ctrl
    import fixvec_irq_pkg::*;
#(
    parameter int VEC_W        = 16,
    parameter int SLOT_SHIFT   = 3,
    parameter int NMI_SLOT     = 4,
    parameter int HS_BASE_SLOT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_in,
    input  logic [HS_N-1:0]    hs_req,
    input  logic               gen_req,
    input  logic               sw_valid,
    input  logic [IDX_W-1:0]   sw_num,
    input  logic               cfg_wr,
    input  logic               cfg_mask_en,
    input  logic [HS_N-1:0]    cfg_mask,
    input  logic               cfg_clr75,
    input  logic               ie_set,
    input  logic               ie_clr,
    input  logic               ack,
    output logic               irq_out,
    output logic [VEC_W-1:0]   vec_out,
    output logic               ext_opcode,
    output logic [2*HS_N:0]    status_out
);

    localparam int              HALF    = 1 << (SLOT_SHIFT - 1);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'((NMI_SLOT << SLOT_SHIFT) + HALF);

    ctl_state_e        state_q, state_d;
    grant_t            gnt_q, sel;
    logic [HS_N-1:0]   mask_q;
    logic              ie_q;

    logic              nmi_pend, gen_q, sw_q;
    logic [HS_N-1:0]   hs_act, hs_ok;
    logic [IDX_W-1:0]  sw_idx_q;
    logic              grant_now, ack_now, sel_maskable;

    assign grant_now    = (state_q == ST_IDLE) && (sel.kind != K_NONE);
    assign ack_now      = (state_q == ST_GRANT) && ack;
    assign sel_maskable = (sel.kind == K_HS) || (sel.kind == K_GEN);
    assign hs_ok        = hs_act & ~mask_q & {HS_N{ie_q}};

    fixvec_irq_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_in    (nmi_in),
        .hs_req    (hs_req),
        .gen_req   (gen_req),
        .sw_valid  (sw_valid),
        .sw_num    (sw_num),
        .nmi_done  (ack_now && gnt_q.kind == K_NMI),
        .top_done  (ack_now && gnt_q.kind == K_HS && gnt_q.idx == IDX_W'(HS_N - 1)),
        .top_flush (cfg_wr && cfg_clr75),
        .nmi_pend  (nmi_pend),
        .hs_act    (hs_act),
        .gen_q     (gen_q),
        .sw_q      (sw_q),
        .sw_idx_q  (sw_idx_q)
    );

    fixvec_irq_prio u_prio (
        .nmi_ok (nmi_pend && nmi_in),
        .hs_ok  (hs_ok),
        .gen_ok (gen_q && ie_q),
        .sw_ok  (sw_q),
        .sw_idx (sw_idx_q),
        .sel    (sel)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transitions IDLE_TO_GRANT and GRANT_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (sel.kind != K_NONE) state_d = ST_GRANT;
            ST_GRANT: if (ack)                state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // winner, mask and global enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_q  <= '{kind: K_NONE, idx: '0};
            mask_q <= '1;
            ie_q   <= 1'b0;
        end else begin
            if (grant_now)
                gnt_q <= sel;
            if (cfg_wr && cfg_mask_en)
                mask_q <= cfg_mask;
            if (grant_now && sel_maskable)
                ie_q <= 1'b0;
            else if (ie_clr)
                ie_q <= 1'b0;
            else if (ie_set)
                ie_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        irq_out    = (state_q == ST_GRANT);
        vec_out    = '0;
        ext_opcode = 1'b0;
        if (state_q == ST_GRANT) begin
            unique case (gnt_q.kind)
                K_NMI:   vec_out = NMI_VEC;
                K_HS:    vec_out = VEC_W'(((HS_BASE_SLOT + int'(gnt_q.idx)) << SLOT_SHIFT) + HALF);
                K_SW:    vec_out = VEC_W'(int'(gnt_q.idx) << SLOT_SHIFT);
                K_GEN:   ext_opcode = 1'b1;
                default: vec_out = '0;
            endcase
        end
    end

    assign status_out = {hs_act, ie_q, mask_q};

endmodule

// File: rtl/fixvec_irq_chk.sv
module fixvec_irq_chk #(
    parameter int VEC_W      = 16,
    parameter int SLOT_SHIFT = 3,
    parameter int NMI_SLOT   = 4,
    parameter int HS_N       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             nmi_in,
    input logic             cfg_wr,
    input logic             cfg_mask_en,
    input logic [HS_N-1:0]  cfg_mask,
    input logic             ack,
    input logic             irq_out,
    input logic [VEC_W-1:0] vec_out,
    input logic             ext_opcode,
    input logic [2*HS_N:0]  status_out
);

    localparam int               HALF    = 1 << (SLOT_SHIFT - 1);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'((NMI_SLOT << SLOT_SHIFT) + HALF);

    logic is_half;
    assign is_half = (vec_out[SLOT_SHIFT-1:0] == SLOT_SHIFT'(HALF)) && (vec_out != NMI_VEC);

    // R5
    ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_opcode |-> (irq_out && vec_out == '0));

    // R10
    hold_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !ack) |=> (irq_out && $stable(vec_out) && $stable(ext_opcode)));

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && ack) |=> !irq_out);

    // R6
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_mask_en) |=> (status_out[HS_N-1:0] == $past(cfg_mask)));

    // R2
    nmi_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_out) && vec_out == NMI_VEC) |-> $past(nmi_in));

    // R8
    ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_out) && (ext_opcode || is_half)) |-> !status_out[HS_N]);

endmodule

bind fixvec_irq_ctrl fixvec_irq_chk #(
    .VEC_W      (VEC_W),
    .SLOT_SHIFT (SLOT_SHIFT),
    .NMI_SLOT   (NMI_SLOT),
    .HS_N       (fixvec_irq_pkg::HS_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nmi_in      (nmi_in),
    .cfg_wr      (cfg_wr),
    .cfg_mask_en (cfg_mask_en),
    .cfg_mask    (cfg_mask),
    .ack         (ack),
    .irq_out     (irq_out),
    .vec_out     (vec_out),
    .ext_opcode  (ext_opcode),
    .status_out  (status_out)
);

// File: tb/tb_fixvec_irq_ctrl.sv
module tb_fixvec_irq_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        nmi_in, gen_req, sw_valid;
    logic [2:0]  hs_req, sw_num, cfg_mask;
    logic        cfg_wr, cfg_mask_en, cfg_clr75, ie_set, ie_clr, ack;
    logic        irq_out, ext_opcode;
    logic [15:0] vec_out;
    logic [6:0]  status_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fixvec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .hs_req(hs_req), .gen_req(gen_req),
        .sw_valid(sw_valid), .sw_num(sw_num), .cfg_wr(cfg_wr), .cfg_mask_en(cfg_mask_en),
        .cfg_mask(cfg_mask), .cfg_clr75(cfg_clr75), .ie_set(ie_set), .ie_clr(ie_clr),
        .ack(ack), .irq_out(irq_out), .vec_out(vec_out), .ext_opcode(ext_opcode),
        .status_out(status_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // kind: 0 none, 1 non-maskable, 2 half-step, 3 general, 4 software
    function automatic int model_kind(input bit nmi, input bit [2:0] hs, input bit gen,
                                      input bit sw, input bit [2:0] mask, input bit ie,
                                      output int hidx);
        hidx = 0;
        if (nmi) return 1;
        for (int k = 2; k >= 0; k--)
            if (hs[k] && !mask[k] && ie) begin hidx = k; return 2; end
        if (gen && ie) return 3;
        if (sw) return 4;
        return 0;
    endfunction

    function automatic logic [15:0] model_vec(input int kind, input int hidx, input bit [2:0] n);
        case (kind)
            1:       return 16'h0024;
            2:       return 16'h002C + 16'(hidx * 8);
            4:       return 16'(n) * 16'd8;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic drive(input bit nmi, input bit [2:0] hs, input bit gen,
                         input bit sw, input bit [2:0] n);
        nmi_in = nmi; hs_req = hs; gen_req = gen; sw_valid = sw; sw_num = n;
    endtask

    task automatic set_cfg(input bit [2:0] m, input bit ie);
        cfg_wr = 1; cfg_mask_en = 1; cfg_mask = m; cfg_clr75 = 1; ie_set = ie; ie_clr = !ie;
        tick();
        cfg_wr = 0; cfg_mask_en = 0; cfg_clr75 = 0; ie_set = 0; ie_clr = 0;
    endtask

    task automatic ack_pulse();
        ack = 1; tick(); ack = 0;
    endtask

    task automatic drain();
        drive(0, 3'b000, 0, 0, 3'd0);
        repeat (4) begin
            tick();
            if (irq_out) ack_pulse();
        end
        cfg_wr = 1; cfg_clr75 = 1; tick(); cfg_wr = 0; cfg_clr75 = 0;
    endtask

    task automatic wait_irq(output bit got);
        got = 0;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (irq_out) begin got = 1; break; end
        end
    endtask

    task automatic no_irq(input int n, input string tag);
        bit seen = 0;
        repeat (n) begin tick(); if (irq_out) seen = 1; end
        chk(tag, 32'(seen), 0);
    endtask

    task automatic run_case(input string tag, input bit nmi, input bit [2:0] hs, input bit gen,
                            input bit sw, input bit [2:0] n, input bit [2:0] m, input bit ie);
        int  kind, hidx;
        bit  got;
        drain();
        set_cfg(m, ie);
        drive(nmi, hs, gen, sw, n);
        kind = model_kind(nmi, hs, gen, sw, m, ie, hidx);
        wait_irq(got);
        chk({tag, " grant R4"}, 32'(got), 32'(kind != 0));
        if (got && kind != 0) begin
            chk({tag, " vector"}, 32'(vec_out), 32'(model_vec(kind, hidx, n)));
            chk({tag, " ext R5"}, 32'(ext_opcode), 32'(kind == 3));
            if (kind == 2 || kind == 3)
                chk({tag, " enable cleared R8"}, 32'(status_out[3]), 0);
            ack_pulse();
            chk({tag, " ack drop R10"}, 32'(irq_out), 0);
        end
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit          got;
        logic [15:0] v0;
        void'($urandom(32'd20240611));
        rst_n = 0; ack = 0;
        drive(0, 3'b000, 0, 0, 3'd0);
        cfg_wr = 0; cfg_mask_en = 0; cfg_mask = 0; cfg_clr75 = 0; ie_set = 0; ie_clr = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R6 R9 reset state
        chk("R6 reset status", 32'(status_out), 32'h07);
        chk("R10 reset irq", 32'(irq_out), 0);

        // R1 every restart slot, with enable off and mask full
        for (int n = 0; n < 8; n++)
            run_case("R1 restart", 0, 3'b000, 0, 1, 3'(n), 3'b111, 0);

        // R3 each half-step address
        for (int k = 0; k < 3; k++)
            run_case("R3 half-step", 0, 3'(1 << k), 0, 0, 3'd0, 3'b000, 1);

        // R5 general line
        run_case("R5 general", 0, 3'b000, 1, 0, 3'd0, 3'b000, 1);
        // R2 non-maskable ignores mask and enable
        run_case("R2 nmi", 0 | 1, 3'b111, 1, 1, 3'd2, 3'b111, 0);
        // R4 ordered pairs
        run_case("R4 hs2 over all", 0, 3'b111, 1, 1, 3'd1, 3'b000, 1);
        run_case("R4 hs1 over hs0", 0, 3'b011, 1, 0, 3'd0, 3'b000, 1);
        run_case("R4 gen over sw", 0, 3'b000, 1, 1, 3'd7, 3'b000, 1);
        // R8 enable off: software still wins
        run_case("R8 enable off", 0, 3'b111, 1, 1, 3'd3, 3'b000, 0);
        // R6 masked top line lets lower through
        run_case("R6 mask hs2", 0, 3'b101, 0, 0, 3'd0, 3'b100, 1);

        // R2 held after ack: no second grant
        drain(); set_cfg(3'b111, 0);
        nmi_in = 1;
        wait_irq(got);
        chk("R2 nmi held grant", 32'(got), 1);
        ack_pulse();
        no_irq(5, "R2 nmi held regrant");
        drain();

        // R2 one-cycle pulse never granted
        nmi_in = 1; tick(); nmi_in = 0;
        no_irq(5, "R2 nmi short pulse");
        drain();

        // R6 R9 masked level shows in status, enable kept
        set_cfg(3'b010, 1);
        hs_req = 3'b010;
        no_irq(4, "R6 masked hs1");
        chk("R9 hs1 level bit", 32'(status_out[5]), 1);
        chk("R9 enable bit", 32'(status_out[3]), 1);
        chk("R9 mask bits", 32'(status_out[2:0]), 32'h2);
        drain();

        // R7 top line latched while masked, cleared by write
        set_cfg(3'b100, 1);
        hs_req = 3'b100; tick(); tick(); hs_req = 3'b000; tick();
        chk("R7 pend latched", 32'(status_out[6]), 1);
        chk("R7 masked no irq", 32'(irq_out), 0);
        cfg_wr = 1; cfg_clr75 = 1; tick(); cfg_wr = 0; cfg_clr75 = 0;
        chk("R7 pend cleared", 32'(status_out[6]), 0);
        cfg_wr = 1; cfg_mask_en = 1; cfg_mask = 3'b000; tick(); cfg_wr = 0; cfg_mask_en = 0;
        no_irq(5, "R7 cleared not served");
        drain();

        // R7 latched pulse served after unmask
        set_cfg(3'b100, 1);
        hs_req = 3'b100; tick(); tick(); hs_req = 3'b000;
        cfg_wr = 1; cfg_mask_en = 1; cfg_mask = 3'b000; tick(); cfg_wr = 0; cfg_mask_en = 0;
        wait_irq(got);
        chk("R7 remembered grant", 32'(got), 1);
        chk("R7 remembered vector", 32'(vec_out), 32'h3C);
        ack_pulse();
        drain();

        // R7 top line held after service: no second grant
        set_cfg(3'b000, 1);
        hs_req = 3'b100;
        wait_irq(got);
        chk("R7 held grant", 32'(got), 1);
        ack_pulse();
        ie_set = 1; tick(); ie_set = 0;
        no_irq(5, "R7 held regrant");
        drain();

        // R7 level withdrawn before enable is never served
        set_cfg(3'b000, 0);
        hs_req = 3'b001; tick(); tick(); hs_req = 3'b000; tick(); tick();
        ie_set = 1; tick(); ie_set = 0;
        no_irq(5, "R7 level withdrawn");
        drain();

        // R10 latency and hold
        set_cfg(3'b000, 0);
        sw_valid = 1; sw_num = 3'd5;
        tick();
        chk("R10 latency early", 32'(irq_out), 0);
        tick();
        chk("R10 latency on time", 32'(irq_out), 1);
        chk("R1 restart 5", 32'(vec_out), 32'h28);
        v0 = vec_out;
        repeat (4) begin
            tick();
            chk("R10 hold irq", 32'(irq_out), 1);
            chk("R10 hold vector", 32'(vec_out), 32'(v0));
        end
        sw_valid = 0;
        ack_pulse();
        chk("R10 drop after ack", 32'(irq_out), 0);
        drain();

        // R4 random mixes
        for (int i = 0; i < 150; i++) begin
            bit       rn, rg, rs, re;
            bit [2:0] rh, rm, rnum;
            rn = ($urandom % 6) == 0;
            rh = 3'($urandom);
            rg = 1'($urandom);
            rs = 1'($urandom);
            rnum = 3'($urandom);
            rm = 3'($urandom);
            re = 1'($urandom);
            run_case("R4 random", rn, rh, rg, rs, rnum, rm, re);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule